// File: doc/BRIEF.md
# Chainable Up/Down Binary Counter

This block is a synchronous binary counter, built from identical small stages that each hold a few bits. Every stage has two count request inputs, one that increments and one that decrements. It also has a parallel preset load and a clearing reset. Each stage produces a carry pulse when it is about to roll over upward and a borrow pulse when it is about to roll over downward. Linking a stage's carry to the next stage's increment input, and its borrow to the next stage's decrement input, makes the chain behave as one wide counter.

The top module instantiates a parameterized number of stages, with two stages of four bits by default. This gives an 8-bit count. The top module wires the terminal outputs of each stage into the one above it. Reset wins over load, and load wins over any count request. All state changes on the single rising clock edge. The carry and borrow of the topmost stage are brought out so that further chains can be attached.

Top module: `udc_chain`

## Requirements
- R1: While `rst` is 1 at a rising edge, the whole count becomes 0 at that edge, whatever `load`, `up_req` and `dn_req` are.
- R2: With `rst` at 0 and `load` at 1, the count takes the value of `preset` at that edge, whatever the count requests are. Stage k takes bits [4k+3:4k] for the default stage width.
- R3: With only `up_req` active, the count rises by one at the edge, and every bit settles on that same edge. The maximum value, 255 with the defaults, wraps to 0.
- R4: With only `dn_req` active, the count falls by one at the edge, and 0 wraps to the maximum value.
- R5: With both requests active, or with neither, and without reset or load, the count holds its value.
- R6: A stage's carry is 1 in the same cycle that its count is all ones and it has an effective increment: the increment is active, the decrement is not, and there is no load or reset. Otherwise the carry is 0.
- R7: A stage's borrow is 1 in the same cycle that its count is zero and it has an effective decrement: the decrement is active, the increment is not, and there is no load or reset. Otherwise the borrow is 0.
- R8: Each higher stage counts up on the carry of the stage below it and down on that stage's borrow. The chained stages therefore match a single counter of the total width. `carry_out` and `borrow_out` are the terminal outputs of the top stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear, highest priority |
| load | input | 1 | Parallel load of `preset` |
| up_req | input | 1 | Increment request to the lowest stage |
| dn_req | input | 1 | Decrement request to the lowest stage |
| preset | input | STAGES*STAGE_W (8) | Value loaded when `load` is 1 |
| count | output | STAGES*STAGE_W (8) | Registered count, stage 0 in the low bits |
| carry_out | output | 1 | Upward terminal pulse of the top stage |
| borrow_out | output | 1 | Downward terminal pulse of the top stage |

## Verification
The count is registered, so the effect of any control presented before a rising edge is due right after that edge. The terminal outputs are combinational from the current count and the current controls, so they are due within the same cycle. The bench changes inputs on the falling edge. It reads `carry_out` and `borrow_out` 1 ns later, before the rising edge, and reads `count` 1 ns after the rising edge, comparing both against an 8-bit arithmetic model. The bench runs full sweeps through both wraparounds and then a long pseudo-random mix of reset, load and requests.

// File: rtl/udc_pkg.sv
package udc_pkg;
  // Resolved action of one stage for the coming edge.
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_INC   = 3'd1,
    OP_DEC   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_CLEAR = 3'd4
  } udc_op_e;
endpackage

// File: rtl/udc_op_decode.sv
module udc_op_decode
  import udc_pkg::*;
(
  input  logic    rst,
  input  logic    load,
  input  logic    up_in,
  input  logic    dn_in,
  output udc_op_e op
);
  // Priority: clear, load, then a single unopposed count request.
  always_comb begin
    if (rst)                 op = OP_CLEAR;
    else if (load)           op = OP_LOAD;
    else if (up_in && !dn_in) op = OP_INC;
    else if (dn_in && !up_in) op = OP_DEC;
    else                     op = OP_HOLD;
  end
endmodule

// File: rtl/udc_stage.sv
module udc_stage
  import udc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         up_in,
  input  logic         dn_in,
  input  logic [W-1:0] preset_in,
  output logic [W-1:0] count_q,
  output logic         carry_o,
  output logic         borrow_o
);
  localparam logic [W-1:0] ZERO  = '0;
  localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MAXV  = '1;

  udc_op_e op;

  udc_op_decode u_dec (
    .rst   (rst),
    .load  (load),
    .up_in (up_in),
    .dn_in (dn_in),
    .op    (op)
  );

  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR: count_q <= ZERO;
      OP_LOAD:  count_q <= preset_in;
      OP_INC:   count_q <= count_q + ONE;
      OP_DEC:   count_q <= count_q - ONE;
      default:  count_q <= count_q;
    endcase
  end

  // Terminal pulses are combinational so a chain moves on one edge.
  assign carry_o  = (op == OP_INC) && (count_q == MAXV);
  assign borrow_o = (op == OP_DEC) && (count_q == ZERO);

  assert_clear_R1: assert property (@(posedge clk)
    rst |=> count_q == ZERO);
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> count_q == $past(preset_in));
  assert_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && up_in && !dn_in) |=> count_q == $past(count_q) + ONE);
  assert_dec_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && dn_in && !up_in) |=> count_q == $past(count_q) - ONE);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && (up_in == dn_in)) |=> $stable(count_q));
  assert_carry_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> count_q == ZERO);
  assert_borrow_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    borrow_o |=> count_q == MAXV);
  assert_terminal_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({carry_o, borrow_o}));
endmodule

// File: rtl/udc_chain.sv
module udc_chain #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic                         up_req,
  input  logic                         dn_req,
  input  logic [STAGES*STAGE_W-1:0]    preset,
  output logic [STAGES*STAGE_W-1:0]    count,
  output logic                         carry_out,
  output logic                         borrow_out
);
  localparam int TOTAL_W = STAGES * STAGE_W;

  // Index k is the request into stage k; index STAGES is the chain output.
  logic [STAGES:0] up_link;
  logic [STAGES:0] dn_link;

  assign up_link[0] = up_req;
  assign dn_link[0] = dn_req;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    udc_stage #(.W(STAGE_W)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .up_in     (up_link[k]),
      .dn_in     (dn_link[k]),
      .preset_in (preset[k*STAGE_W +: STAGE_W]),
      .count_q   (count[k*STAGE_W +: STAGE_W]),
      .carry_o   (up_link[k+1]),
      .borrow_o  (dn_link[k+1])
    );
  end

  assign carry_out  = up_link[STAGES];
  assign borrow_out = dn_link[STAGES];

  // Whole-chain behaviour against a single wide counter.
  localparam logic [TOTAL_W-1:0] T_ONE = {{(TOTAL_W-1){1'b0}}, 1'b1};
  assert_chain_inc_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && up_req && !dn_req) |=> count == $past(count) + T_ONE);
  assert_chain_dec_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && dn_req && !up_req) |=> count == $past(count) - T_ONE);
endmodule

// File: tb/udc_chain_bench.sv
module udc_chain_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic         up_req = 1'b0;
  logic         dn_req = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic         carry_out;
  logic         borrow_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [W-1:0] model = '0;
  logic [15:0]  lfsr = 16'hACE1;

  udc_chain u_udc_chain (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .up_req     (up_req),
    .dn_req     (dn_req),
    .preset     (preset),
    .count      (count),
    .carry_out  (carry_out),
    .borrow_out (borrow_out)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive on falling edge, check terminals before the rise,
  // check the count just after the rise.
  task automatic step(input logic r, input logic l, input logic u, input logic d,
                      input logic [W-1:0] p);
    logic eff_up, eff_dn;
    logic [W-1:0] nxt;
    string tag;
    @(negedge clk);
    rst = r; load = l; up_req = u; dn_req = d; preset = p;
    #1;
    eff_up = !r && !l && u && !d;
    eff_dn = !r && !l && d && !u;
    check("R6/R8 carry_out", {7'd0, carry_out}, {7'd0, eff_up && (model == 8'hFF)});
    check("R7/R8 borrow_out", {7'd0, borrow_out}, {7'd0, eff_dn && (model == 8'h00)});
    if (r)           begin nxt = 8'h00;        tag = "R1 count"; end
    else if (l)      begin nxt = p;            tag = "R2 count"; end
    else if (eff_up) begin nxt = model + 8'd1; tag = "R3/R8 count"; end
    else if (eff_dn) begin nxt = model - 8'd1; tag = "R4/R8 count"; end
    else             begin nxt = model;        tag = "R5 count"; end
    @(posedge clk);
    #1;
    model = nxt;
    check(tag, count, model);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(1, 0, 0, 0, 8'h00);
    step(1, 1, 1, 0, 8'h5A);
    // R3, R6, R8: full upward sweep with wrap 255 -> 0
    for (int i = 0; i < 260; i++) step(0, 0, 1, 0, 8'h00);
    // R4, R7, R8: full downward sweep with wrap 0 -> 255
    for (int i = 0; i < 260; i++) step(0, 0, 0, 1, 8'h00);
    // R5: both requests, then neither
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 8'h00);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 8'h00);
    // R2: load during counting, then count from there
    step(0, 1, 1, 0, 8'hA5);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 8'h00);
    step(0, 1, 0, 1, 8'h0F);
    for (int i = 0; i < 17; i++) step(0, 0, 0, 1, 8'h00);
    step(0, 1, 0, 0, 8'hFF);
    step(0, 0, 1, 0, 8'h00);
    step(0, 1, 0, 0, 8'h00);
    step(0, 0, 0, 1, 8'h00);
    // R1: reset during load
    step(0, 1, 0, 0, 8'h33);
    step(1, 1, 0, 0, 8'h77);
    // Mixed pseudo-random traffic over all controls
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] == 4'd0, lfsr[7:4] == 4'd0, lfsr[8], lfsr[9] & lfsr[10], lfsr[15:8]);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule